// File: doc/BRIEF.md
# Maskable Interrupt Request Controller

This block gathers interrupt requests for a small 4-bit processor and folds them into one interrupt line. Requests come from two kinds of source. There are four external pins, and each one raises a request on a rising or a falling transition, chosen per pin. There are also eight internal request strobes from peripherals. Every request is latched into a sticky flag. Each flag has an enable bit in a mask register. A global enable bit gates the interrupt line to the processor.

Software sees the block as 4-bit registers on a simple read/write strobe port. Reading a flag register returns its flags and clears them in the same access. Writing a flag register clears the flags at the positions written as 1. When the processor enters its halt state, the global enable turns on by itself, so that a pending request can wake it. The register port has no handshake and never stalls: every strobe completes in the cycle it is presented, and read data is valid in that same cycle.

Top module: `irqc_top`

## Requirements
- R1: After reset every flag, mask and polarity bit is 0, the global enable is 0, irq_o is 0, and all eight registers read 0.
- R2: A high internal request bit j during a clock edge sets flag j. Flags 0–3 are in register 1 at bits 0–3, and flags 4–7 are in register 2 at bits 0–3.
- R3: External pin i sets flag i in register 0 (bit i) on a transition. Polarity register 6 bit i equal to 0 selects the rising transition and 1 selects the falling one. The opposite transition leaves the flag unchanged.
- R4: A flag whose mask bit is 0 is still set by its request but does not assert irq_o. The mask registers are 3 (external), 4 (internal 0–3) and 5 (internal 4–7), and mask bit 1 enables the flag.
- R5: irq_o is high in the same cycle exactly when the global enable is 1 and at least one flag has its mask bit set.
- R6: A read of a flag register returns the current flags and clears every flag of that register at the end of the access cycle.
- R7: A write to a flag register clears the flags whose wdata bit is 1 and leaves the others unchanged.
- R8: A request that arrives in the same cycle as a read-clear or a write-clear of its flag leaves the flag set.
- R9: Register 7 bit 0 is the global enable and reads back in bit 0, with bits 3–1 reading 0. Writing it to 0 forces irq_o low while flags stay pending.
- R10: A 0-to-1 transition of halt_i sets the global enable, and this takes priority over a write of 0 in the same cycle. While halt_i stays high the enable can still be cleared by a write.
- R11: The mask and polarity registers read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_req_i | input | N_EXT (4) | External request pins, level inputs synchronous to clk_i |
| int_req_i | input | N_INT (8) | Internal request strobes, one cycle each |
| halt_i | input | 1 | Processor is in halt state |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W (3) | Register address |
| reg_wdata_i | input | DW (4) | Write data |
| reg_rdata_o | output | DW (4) | Read data, valid in the strobe cycle |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The bench builds the block with its default parameters: four external pins, eight internal sources and a 4-bit data width. This gives three flag registers and three mask registers, and together with the polarity and control registers it fills every one of the eight addresses. That layout places internal flags on both sides of a word boundary, so the word split is exercised. It also lets a reference model check every readable location and compare the interrupt line on each cycle. Collisions between requests and clears, and between halt entry and a disabling write, are driven in the same cycle on purpose.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  typedef enum logic [2:0] {
    RK_FLAG,
    RK_MASK,
    RK_POL,
    RK_CTRL,
    RK_NONE
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e  kind;
    logic [7:0] idx;
  } reg_sel_t;

  function automatic int unsigned ceil_div(input int unsigned a, input int unsigned b);
    return (a + b - 1) / b;
  endfunction

  // Layout: flag words, then mask words, then polarity words, then control.
  function automatic reg_sel_t decode_addr(input int unsigned a,
                                           input int unsigned fw,
                                           input int unsigned ew);
    reg_sel_t s;
    s.kind = RK_NONE;
    s.idx  = '0;
    if (a < fw) begin
      s.kind = RK_FLAG;
      s.idx  = 8'(a);
    end else if (a < 2 * fw) begin
      s.kind = RK_MASK;
      s.idx  = 8'(a - fw);
    end else if (a < 2 * fw + ew) begin
      s.kind = RK_POL;
      s.idx  = 8'(a - 2 * fw);
    end else if (a == 2 * fw + ew) begin
      s.kind = RK_CTRL;
    end
    return s;
  endfunction

endpackage

// File: rtl/irqc_edge_detect.sv
module irqc_edge_detect #(
  parameter int unsigned N_EXT = 4
) (
  input  logic             clk_i,
  input  logic [N_EXT-1:0] pin_i,
  input  logic [N_EXT-1:0] fall_sel_i,
  output logic [N_EXT-1:0] hit_o
);

  // Tracks the pins through reset too, so no false transition appears at release.
  logic [N_EXT-1:0] last_q;

  always_ff @(posedge clk_i) begin
    last_q <= pin_i;
  end

  for (genvar g = 0; g < N_EXT; g++) begin : g_pin
    always_comb begin
      if (fall_sel_i[g]) hit_o[g] = last_q[g] & ~pin_i[g];
      else               hit_o[g] = ~last_q[g] & pin_i[g];
    end
  end

endmodule

// File: rtl/irqc_flag_bank.sv
module irqc_flag_bank #(
  parameter int unsigned DW    = 4,
  parameter int unsigned WORDS = 3,
  localparam int unsigned NB   = DW * WORDS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NB-1:0]    set_i,
  input  logic [WORDS-1:0] rd_clr_i,
  input  logic [WORDS-1:0] wr_clr_i,
  input  logic [DW-1:0]    wr_bits_i,
  output logic [NB-1:0]    flags_o
);

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [DW-1:0] clr;
    logic [DW-1:0] word_q;

    always_comb begin
      clr = '0;
      if (rd_clr_i[w]) clr = '1;
      if (wr_clr_i[w]) clr = clr | wr_bits_i;
    end

    // New requests take priority over clearing, so none is lost.
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) word_q <= '0;
      else         word_q <= (word_q & ~clr) | set_i[w*DW +: DW];
    end

    assign flags_o[w*DW +: DW] = word_q;

    AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_clr_i[w] && !wr_clr_i[w] && (set_i[w*DW +: DW] == '0)) |=> (word_q == '0)); // R6

    AST_WRITE_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_clr_i[w] && !rd_clr_i[w]) |=>
        ((word_q & $past(word_q & ~wr_bits_i)) == $past(word_q & ~wr_bits_i))); // R7
  end

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((flags_o & $past(set_i)) == $past(set_i))); // R8

endmodule

// File: rtl/irqc_cfg_regs.sv
module irqc_cfg_regs #(
  parameter int unsigned DW     = 4,
  parameter int unsigned FWORDS = 3,
  parameter int unsigned EWORDS = 1,
  localparam int unsigned MB    = DW * FWORDS,
  localparam int unsigned PB    = DW * EWORDS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FWORDS-1:0] mask_wr_i,
  input  logic [EWORDS-1:0] pol_wr_i,
  input  logic              ctrl_wr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              halt_i,
  output logic [MB-1:0]     mask_o,
  output logic [PB-1:0]     pol_o,
  output logic              gen_en_o
);

  for (genvar w = 0; w < FWORDS; w++) begin : g_mask
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           mask_o[w*DW +: DW] <= '0;
      else if (mask_wr_i[w]) mask_o[w*DW +: DW] <= wdata_i;
    end
  end

  for (genvar w = 0; w < EWORDS; w++) begin : g_pol
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          pol_o[w*DW +: DW] <= '0;
      else if (pol_wr_i[w]) pol_o[w*DW +: DW] <= wdata_i;
    end
  end

  logic halt_q;
  logic halt_entry;

  assign halt_entry = halt_i & ~halt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_q   <= 1'b0;
      gen_en_o <= 1'b0;
    end else begin
      halt_q <= halt_i;
      if (halt_entry)     gen_en_o <= 1'b1;
      else if (ctrl_wr_i) gen_en_o <= wdata_i[0];
    end
  end

  AST_HALT_ENABLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halt_i) |=> gen_en_o); // R10

endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int unsigned N_EXT  = 4,
  parameter int unsigned N_INT  = 8,
  parameter int unsigned DW     = 4,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_EXT-1:0]  ext_req_i,
  input  logic [N_INT-1:0]  int_req_i,
  input  logic              halt_i,
  input  logic              reg_rd_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  output logic              irq_o
);

  localparam int unsigned EWORDS = ceil_div(N_EXT, DW);
  localparam int unsigned IWORDS = ceil_div(N_INT, DW);
  localparam int unsigned FWORDS = EWORDS + IWORDS;
  localparam int unsigned EBITS  = EWORDS * DW;
  localparam int unsigned FBITS  = FWORDS * DW;

  reg_sel_t sel;
  assign sel = decode_addr(32'(reg_addr_i), FWORDS, EWORDS);

  logic [FWORDS-1:0] rd_clr;
  logic [FWORDS-1:0] wr_clr;
  logic [FWORDS-1:0] mask_wr;
  logic [EWORDS-1:0] pol_wr;
  logic              ctrl_wr;

  for (genvar w = 0; w < FWORDS; w++) begin : g_fstrb
    assign rd_clr[w]  = reg_rd_i && (sel.kind == RK_FLAG) && (sel.idx == 8'(w));
    assign wr_clr[w]  = reg_wr_i && (sel.kind == RK_FLAG) && (sel.idx == 8'(w));
    assign mask_wr[w] = reg_wr_i && (sel.kind == RK_MASK) && (sel.idx == 8'(w));
  end

  for (genvar w = 0; w < EWORDS; w++) begin : g_pstrb
    assign pol_wr[w] = reg_wr_i && (sel.kind == RK_POL) && (sel.idx == 8'(w));
  end

  assign ctrl_wr = reg_wr_i && (sel.kind == RK_CTRL);

  logic [FBITS-1:0] mask;
  logic [EBITS-1:0] pol;
  logic             gen_en;

  irqc_cfg_regs #(
    .DW(DW), .FWORDS(FWORDS), .EWORDS(EWORDS)
  ) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mask_wr_i (mask_wr),
    .pol_wr_i  (pol_wr),
    .ctrl_wr_i (ctrl_wr),
    .wdata_i   (reg_wdata_i),
    .halt_i    (halt_i),
    .mask_o    (mask),
    .pol_o     (pol),
    .gen_en_o  (gen_en)
  );

  logic [N_EXT-1:0] ext_hit;

  irqc_edge_detect #(.N_EXT(N_EXT)) u_edge (
    .clk_i      (clk_i),
    .pin_i      (ext_req_i),
    .fall_sel_i (pol[N_EXT-1:0]),
    .hit_o      (ext_hit)
  );

  // External sources fill the low words, internal sources start on a fresh word.
  logic [FBITS-1:0] set_vec;
  always_comb begin
    set_vec = '0;
    set_vec[N_EXT-1:0]       = ext_hit;
    set_vec[EBITS +: N_INT]  = int_req_i;
  end

  logic [FBITS-1:0] flags;

  irqc_flag_bank #(.DW(DW), .WORDS(FWORDS)) u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (set_vec),
    .rd_clr_i  (rd_clr),
    .wr_clr_i  (wr_clr),
    .wr_bits_i (reg_wdata_i),
    .flags_o   (flags)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (sel.kind)
      RK_FLAG: reg_rdata_o = flags[int'(sel.idx)*DW +: DW];
      RK_MASK: reg_rdata_o = mask[int'(sel.idx)*DW +: DW];
      RK_POL:  reg_rdata_o = pol[int'(sel.idx)*DW +: DW];
      RK_CTRL: reg_rdata_o = DW'(gen_en);
      default: reg_rdata_o = '0;
    endcase
  end

  assign irq_o = gen_en & (|(flags & mask));

  for (genvar g = 0; g < N_EXT; g++) begin : g_ext_chk
    AST_EXT_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(ext_req_i[g]) && !pol[g]) |=> flags[g]); // R3
    AST_EXT_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($fell(ext_req_i[g]) && pol[g]) |=> flags[g]); // R3
  end

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (gen_en && (flags != '0))); // R5

endmodule

// File: tb/irqc_top_tb_top.sv
module irqc_top_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] ext = '0;
  logic [7:0] ireq = '0;
  logic       halt = 1'b0;
  logic       rd = 1'b0;
  logic       wr = 1'b0;
  logic [2:0] addr = '0;
  logic [3:0] wdata = '0;
  logic [3:0] rdata;
  logic       irq;

  int    checks = 0;
  int    fails = 0;
  int    cycles = 0;
  bit    finished = 1'b0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  irqc_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ext_req_i(ext), .int_req_i(ireq),
    .halt_i(halt), .reg_rd_i(rd), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  // Reference model: flag index 0..3 external, 4..11 internal.
  bit [11:0] m_flag, m_mask;
  bit [3:0]  m_pol, m_prev;
  bit        m_gen, m_halt_q;

  function automatic bit [3:0] m_read(input int a);
    if (a <= 2)      return m_flag[a*4 +: 4];
    else if (a <= 5) return m_mask[(a-3)*4 +: 4];
    else if (a == 6) return m_pol;
    else             return {3'b000, m_gen};
  endfunction

  always @(posedge clk) begin : model
    bit [11:0] set_v;
    bit [11:0] clr_v;
    if (!rst_n) begin
      m_flag = '0; m_mask = '0; m_pol = '0; m_gen = 1'b0; m_halt_q = 1'b0;
    end else begin
      set_v = '0;
      for (int i = 0; i < 4; i++) begin
        if (m_pol[i]) set_v[i] = m_prev[i] && !ext[i];
        else          set_v[i] = !m_prev[i] && ext[i];
      end
      for (int j = 0; j < 8; j++) set_v[4+j] = ireq[j];
      clr_v = '0;
      if (rd && addr <= 2) clr_v[addr*4 +: 4] = 4'hF;
      if (wr && addr <= 2) clr_v[addr*4 +: 4] = wdata;
      m_flag = (m_flag & ~clr_v) | set_v;
      if (wr && addr >= 3 && addr <= 5) m_mask[(addr-3)*4 +: 4] = wdata;
      if (wr && addr == 6) m_pol = wdata;
      if (wr && addr == 7) m_gen = wdata[0];
      if (halt && !m_halt_q) m_gen = 1'b1;
      m_halt_q = halt;
    end
    m_prev = ext;
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(irq == (m_gen && ((m_flag & m_mask) != 0)), "irq_o", irq,
          m_gen && ((m_flag & m_mask) != 0));
      if (rd) chk(rdata == m_read(addr), "reg_rdata_o", rdata, m_read(addr));
    end
  end

  task automatic op(input bit r, input bit w, input int a, input bit [3:0] d, input bit [7:0] ir);
    @(posedge clk); #1;
    rd = r; wr = w; addr = 3'(a); wdata = d; ireq = ir;
  endtask
  task automatic nop();                              op(0, 0, 0, 0, 0);     endtask
  task automatic rdr(input int a);                   op(1, 0, a, 0, 0);     endtask
  task automatic wrr(input int a, input bit [3:0] d); op(0, 1, a, d, 0);    endtask
  task automatic pulse(input bit [7:0] ir);          op(0, 0, 0, 0, ir);    endtask
  task automatic set_ext(input bit [3:0] v);
    @(posedge clk); #1; rd = 0; wr = 0; ireq = 0; ext = v;
  endtask
  task automatic set_halt(input bit v);
    @(posedge clk); #1; rd = 0; wr = 0; ireq = 0; halt = v;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    cur_req = "R1";
    nop();
    chk(irq == 1'b0, "irq_o after reset", irq, 0);
    for (int a = 0; a < 8; a++) rdr(a);

    cur_req = "R11";
    wrr(3, 4'hA); wrr(4, 4'h5); wrr(5, 4'hC); wrr(6, 4'h3); wrr(7, 4'h1);
    for (int a = 3; a < 8; a++) rdr(a);
    wrr(3, 0); wrr(4, 0); wrr(5, 0); wrr(6, 0); wrr(7, 0);

    cur_req = "R2";
    pulse(8'b0010_0001); nop();
    rdr(1); rdr(2); rdr(1);

    cur_req = "R3";
    set_ext(4'b0001); nop(); rdr(0);
    set_ext(4'b0000); nop(); rdr(0);
    wrr(6, 4'b0010);
    set_ext(4'b0010); nop(); rdr(0);
    set_ext(4'b0000); nop(); rdr(0);
    wrr(6, 0);

    cur_req = "R4";
    pulse(8'hFF); wrr(7, 1); nop(); nop();
    rdr(1);

    cur_req = "R5";
    wrr(5, 4'b0001); nop(); wrr(5, 4'b0000); nop(); wrr(5, 4'b0001); nop();

    cur_req = "R9";
    wrr(7, 0); nop(); rdr(7); wrr(7, 1); nop(); rdr(7);

    cur_req = "R6";
    rdr(2); nop(); rdr(2);

    cur_req = "R7";
    pulse(8'hF0); wrr(2, 4'b0101); rdr(2);

    cur_req = "R8";
    pulse(8'h0F); op(1, 0, 1, 0, 8'b0000_0010); rdr(1);
    op(0, 1, 1, 4'hF, 8'b0000_0100); rdr(1);

    cur_req = "R10";
    wrr(5, 4'hF); pulse(8'h10); wrr(7, 0); nop();
    set_halt(1'b1); nop(); rdr(7);
    wrr(7, 0); nop(); rdr(7);
    set_halt(1'b0); nop();
    @(posedge clk); #1; rd = 0; ireq = 0; wr = 1; addr = 3'd7; wdata = 4'h0; halt = 1'b1;
    nop(); rdr(7);
    set_halt(1'b0); nop(); nop();

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule